// File: doc/BRIEF.md
# Configurable Pixel Component Extractor

This block sits between a framebuffer fetch path and a display output serialiser. Each cycle it takes one raw pixel word and turns it into three 8-bit colour components: red, green and blue. Every colour has its own 32-bit select word. The select word gives the lowest bit position of that colour's field inside the pixel word, how many bits wide the field is, and a fallback colour value.

A shared format word gives the number of bytes that make up one pixel. Bytes of the pixel word above that count are cleared before any field is cut out. A colour shows its fallback value in three cases: its width field is zero, the pixel lies in the blanking region (data-enable low), or the pixel source reports an underrun.

A field narrower than 8 bits is widened by repeating its own bits, so full-scale input gives full-scale output. All three outputs and the data-enable are registered together, so every output has exactly one cycle of latency. The block is pure datapath and has no states: a new result is produced on every clock.

Top module: `pce_extract`

## Requirements
- R1: Each select word holds the field's lowest bit position in bits [4:0], the field width in bits [11:8] and the fallback colour in bits [23:16]. For a width from 1 to 8, the output is taken from pixel bits starting at that position.
- R2: A width field of zero makes that colour output its fallback value, whatever the pixel word holds.
- R3: When `de_i` is low, all three colours output their fallback values.
- R4: When `underrun_i` is high, all three colours output their fallback values, even while `de_i` is high.
- R5: Format word bits [4:3] hold the byte count minus one (0 means 1 byte, 3 means 4 bytes). Pixel bytes at or above that count read as zero before extraction.
- R6: A field of width W below 8 is placed in the top W output bits. The bits below are filled by repeating the field from its top bit downward. For example, 3-bit value 101 becomes 10110110.
- R7: For a width from 9 to 15, the output is the 8 most significant bits of the extracted field.
- R8: Field bits whose position would lie at or beyond pixel bit 32 read as zero.
- R9: The colour outputs and `de_o` reflect the inputs sampled at the previous rising clock edge. Reset drives all of them to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pix_i | input | 32 | Raw pixel word from the fetch path |
| de_i | input | 1 | High while the pixel is in the visible area |
| underrun_i | input | 1 | High when the pixel source has no valid data |
| fmt_i | input | 32 | Format word; bits [4:3] hold bytes per pixel minus one |
| sel_red_i | input | 32 | Red select word |
| sel_grn_i | input | 32 | Green select word |
| sel_blu_i | input | 32 | Blue select word |
| red_o | output | 8 | Red component |
| grn_o | output | 8 | Green component |
| blu_o | output | 8 | Blue component |
| de_o | output | 1 | Data-enable delayed to match the colours |

## Verification
The only state is the output register stage. Any fault in the shift, mask, replication or fallback logic therefore appears at the colour ports one clock after the offending input, on exactly that pixel, with no build-up across cycles. The sweeps cover every offset, width and byte count. This way a wrong shift amount, an off-by-one in the clearing of unused bytes or in the width mask, or a bad replication index shows up as a wrong value on the pixel that triggers it. A data-enable path that is misaligned by a cycle shows up immediately as `de_o` disagreeing with the previous cycle's `de_i`.

// File: rtl/pce_pkg.sv
package pce_pkg;
    localparam int SEL_OFF_LSB = 0;
    localparam int SEL_LEN_LSB = 8;
    localparam int SEL_LEN_W   = 4;
    localparam int SEL_DEF_LSB = 16;
    localparam int FMT_BPP_LSB = 3;
    localparam int NUM_COLOURS = 3;
    typedef enum logic [1:0] {
        COL_RED = 2'd0,
        COL_GRN = 2'd1,
        COL_BLU = 2'd2
    } colour_e;
endpackage

// File: rtl/pce_bytemask.sv
module pce_bytemask
    import pce_pkg::*;
#(
    parameter int PIX_W = 32
) (
    input  logic [PIX_W-1:0] pix_i,
    input  logic [31:0]      fmt_i,
    output logic [PIX_W-1:0] pix_o
);
    localparam int NBYTES = PIX_W / 8;
    localparam int BPP_W  = (NBYTES > 1) ? $clog2(NBYTES) : 1;

    logic [BPP_W-1:0] last_byte;
    assign last_byte = fmt_i[FMT_BPP_LSB +: BPP_W];

    for (genvar b = 0; b < NBYTES; b++) begin : g_byte
        assign pix_o[b*8 +: 8] = (BPP_W'(b) <= last_byte) ? pix_i[b*8 +: 8] : 8'h00;
    end
endmodule

// File: rtl/pce_lane.sv
module pce_lane
    import pce_pkg::*;
#(
    parameter int PIX_W  = 32,
    parameter int COMP_W = 8
) (
    input  logic [PIX_W-1:0]  pix_i,
    input  logic [31:0]       sel_i,
    input  logic              de_i,
    input  logic              underrun_i,
    output logic [COMP_W-1:0] comp_o
);
    localparam int OFF_W = $clog2(PIX_W);

    logic [OFF_W-1:0]     off;
    logic [SEL_LEN_W-1:0] len;
    logic [COMP_W-1:0]    fallback;
    logic [PIX_W-1:0]     shifted;
    logic [COMP_W-1:0]    field;
    logic [COMP_W-1:0]    widened;
    int                   eff_len;

    assign off      = sel_i[SEL_OFF_LSB +: OFF_W];
    assign len      = sel_i[SEL_LEN_LSB +: SEL_LEN_W];
    assign fallback = sel_i[SEL_DEF_LSB +: COMP_W];

    always_comb begin
        shifted = pix_i >> off;
        for (int k = 0; k < PIX_W; k++) begin
            if (k >= int'(len)) shifted[k] = 1'b0;
        end
        if (int'(len) > COMP_W) begin
            shifted = shifted >> (int'(len) - COMP_W);
            eff_len = COMP_W;
        end else begin
            eff_len = int'(len);
        end
        field   = shifted[COMP_W-1:0];
        widened = '0;
        if (eff_len > 0) begin
            for (int i = 0; i < COMP_W; i++) begin
                widened[i] = field[eff_len - 1 - ((COMP_W - 1 - i) % eff_len)];
            end
        end
    end

    always_comb begin
        if (!de_i || underrun_i || (len == '0)) comp_o = fallback;
        else                                     comp_o = widened;
    end
endmodule

// File: rtl/pce_extract.sv
module pce_extract
    import pce_pkg::*;
#(
    parameter int PIX_W  = 32,
    parameter int COMP_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PIX_W-1:0]  pix_i,
    input  logic              de_i,
    input  logic              underrun_i,
    input  logic [31:0]       fmt_i,
    input  logic [31:0]       sel_red_i,
    input  logic [31:0]       sel_grn_i,
    input  logic [31:0]       sel_blu_i,
    output logic [COMP_W-1:0] red_o,
    output logic [COMP_W-1:0] grn_o,
    output logic [COMP_W-1:0] blu_o,
    output logic              de_o
);
    logic [PIX_W-1:0]  pix_clean;
    logic [31:0]       sel_a  [NUM_COLOURS];
    logic [COMP_W-1:0] comp_a [NUM_COLOURS];
    logic [COMP_W-1:0] comp_q [NUM_COLOURS];

    assign sel_a[COL_RED] = sel_red_i;
    assign sel_a[COL_GRN] = sel_grn_i;
    assign sel_a[COL_BLU] = sel_blu_i;

    pce_bytemask #(.PIX_W(PIX_W)) u_mask (
        .pix_i (pix_i),
        .fmt_i (fmt_i),
        .pix_o (pix_clean)
    );

    for (genvar c = 0; c < NUM_COLOURS; c++) begin : g_lane
        pce_lane #(.PIX_W(PIX_W), .COMP_W(COMP_W)) u_lane (
            .pix_i      (pix_clean),
            .sel_i      (sel_a[c]),
            .de_i       (de_i),
            .underrun_i (underrun_i),
            .comp_o     (comp_a[c])
        );

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) comp_q[c] <= '0;
            else        comp_q[c] <= comp_a[c];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) de_o <= 1'b0;
        else        de_o <= de_i;
    end

    assign red_o = comp_q[COL_RED];
    assign grn_o = comp_q[COL_GRN];
    assign blu_o = comp_q[COL_BLU];

    AST_DE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (de_o == $past(de_i))); // R9
    AST_ZERO_LEN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_red_i[SEL_LEN_LSB +: SEL_LEN_W] == '0) |=>
        (red_o == $past(sel_red_i[SEL_DEF_LSB +: COMP_W]))); // R2
    AST_BLANK_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        !de_i |=> (grn_o == $past(sel_grn_i[SEL_DEF_LSB +: COMP_W]))); // R3
    AST_UNDERRUN_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
        underrun_i |=> (blu_o == $past(sel_blu_i[SEL_DEF_LSB +: COMP_W]))); // R4
    AST_BLANK_DE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !de_i |=> !de_o); // R9
endmodule

// File: tb/pce_extract_test.sv
module pce_extract_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pix = '0;
    logic        de = 1'b0;
    logic        und = 1'b0;
    logic [31:0] fmt = '0;
    logic [31:0] sel_r = '0, sel_g = '0, sel_b = '0;
    logic [7:0]  red, grn, blu;
    logic        de_out;
    int          checks = 0;
    int          errors = 0;
    bit          done = 1'b0;

    always #10 clk = ~clk;

    pce_extract uut (
        .clk(clk), .rst_n(rst_n), .pix_i(pix), .de_i(de), .underrun_i(und),
        .fmt_i(fmt), .sel_red_i(sel_r), .sel_grn_i(sel_g), .sel_blu_i(sel_b),
        .red_o(red), .grn_o(grn), .blu_o(blu), .de_o(de_out)
    );

    function automatic logic [7:0] model(input logic [31:0] word, input logic [31:0] f,
                                         input logic [31:0] s, input bit d, input bit u);
        longint w, fld, acc;
        int nbytes, off, len, bits;
        nbytes = int'(f[4:3]) + 1;
        off    = int'(s[4:0]);
        len    = int'(s[11:8]);
        if (!d || u || len == 0) return s[23:16];
        w   = longint'(word) & ((64'd1 << (8*nbytes)) - 1);
        fld = (w >> off) & ((64'd1 << len) - 1);
        if (len > 8) begin
            fld = fld >> (len - 8);
            len = 8;
        end
        acc = 0; bits = 0;
        while (bits < 8) begin
            acc = (acc << len) | fld;
            bits += len;
        end
        return 8'(acc >> (bits - 8));
    endfunction

    function automatic string tag_of(input logic [31:0] f, input logic [31:0] s,
                                     input bit d, input bit u);
        int n, o, l;
        n = (int'(f[4:3]) + 1) * 8; o = int'(s[4:0]); l = int'(s[11:8]);
        if (!d) return "R3";
        if (u) return "R4";
        if (l == 0) return "R2";
        if (o + l > 32) return "R8";
        if (o + l > n) return "R5";
        if (l > 8) return "R7";
        if (l < 8) return "R6";
        return "R1";
    endfunction

    task automatic check8(input string req, input string what, input logic [7:0] act,
                          input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%02h expected=%02h", req, what, act, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w, input logic [31:0] f, input logic [31:0] sr,
                         input logic [31:0] sg, input logic [31:0] sb, input bit d, input bit u);
        logic [7:0] er, eg, eb;
        @(negedge clk);
        pix = w; fmt = f; sel_r = sr; sel_g = sg; sel_b = sb; de = d; und = u;
        er = model(w, f, sr, d, u);
        eg = model(w, f, sg, d, u);
        eb = model(w, f, sb, d, u);
        @(negedge clk);
        check8(tag_of(f, sr, d, u), "red", red, er);
        check8(tag_of(f, sg, d, u), "grn", grn, eg);
        check8(tag_of(f, sb, d, u), "blu", blu, eb);
        check8("R9", "de", {7'd0, de_out}, {7'd0, d});
    endtask

    initial begin
        logic [31:0] words [3];
        words[0] = 32'hA5C3_96E1;
        words[1] = 32'hFFFF_FFFF;
        words[2] = 32'h1234_5678;
        #5;
        check8("R9", "reset red", red, 8'h00);
        check8("R9", "reset de", {7'd0, de_out}, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R1 R5 R6 R7 R8 sweep: every offset, width and byte count
        for (int wi = 0; wi < 3; wi++)
            for (int fb = 0; fb < 4; fb++)
                for (int off = 0; off < 32; off++)
                    for (int len = 0; len < 16; len++)
                        apply(words[wi], 32'(fb) << 3,
                              {8'h00, 8'h3C, 4'h0, 4'(len), 3'b0, 5'(off)},
                              {8'h00, 8'hC3, 4'h0, 4'(15 - len), 3'b0, 5'(31 - off)},
                              {8'h00, 8'h5A, 4'h0, 4'(len), 3'b0, 5'((off + 8) % 32)},
                              1'b1, 1'b0);

        // R3 blanking and R4 underrun with non-zero widths
        apply(32'hDEAD_BEEF, 32'h18, 32'h0011_0800, 32'h0022_0808, 32'h0033_0810, 1'b0, 1'b0);
        apply(32'hDEAD_BEEF, 32'h18, 32'h0011_0800, 32'h0022_0808, 32'h0033_0810, 1'b1, 1'b1);
        apply(32'hDEAD_BEEF, 32'h18, 32'h0011_0800, 32'h0022_0808, 32'h0033_0810, 1'b0, 1'b1);
        // R6 explicit: 3-bit 101 -> 10110110
        apply(32'h0000_0005, 32'h18, 32'h0000_0300, 32'h0000_0300, 32'h0000_0300, 1'b1, 1'b0);
        check8("R6", "literal widen", red, 8'hB6);
        // R8 explicit: offset 28 width 8 keeps only top nibble 0xF -> 00001111
        apply(32'hF000_0000, 32'h18, 32'h0000_081C, 32'h0000_081C, 32'h0000_081C, 1'b1, 1'b0);
        check8("R8", "past end", red, 8'h0F);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                errors++;
                checks++;
                $display("FAIL watchdog actual=running expected=finished");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule